// File: doc/BRIEF.md
# Call/Return Frame State Save Unit

This block keeps the live procedure state of a processor: a two-bit privilege level, a six-bit epilog count and a 38-bit frame marker. The frame marker describes how the stacked register window is split into frame size, locals size and rotating-region size. It also holds the three rotating-base offsets for the general, floating-point and predicate registers. Next to the live state sits one previous-state register. It stores the caller's privilege level, epilog count and frame marker as a single 46-bit word.

A call event copies the live triple into the previous-state register and clears the rotating bases of the new frame. A return event loads the saved triple back into the live state. Only one level is held, so code that makes nested calls must spill the previous-state register and reload it through the direct read and write port. Only the allocate command changes the size fields. Only loop rotation, call and return change the rotating bases. Privilege level and epilog count have their own write strobes.

Top module: `frame_state_unit`

## Requirements
- R1: After reset, `pl_o`, `ec_o`, `cfm_o` and `pfs_o` are all zero.
- R2: One cycle after `call_i`, `pfs_o` equals {pl, ec, cfm} as they were before the call: privilege level in bits 45:44, epilog count in bits 43:38 and frame marker in bits 37:0.
- R3: A call clears the rotating-base fields (`cfm_o` bits 37:18) and leaves the size fields (bits 17:0) unchanged.
- R4: A return without a call in the same cycle loads `pl_o`, `ec_o` and `cfm_o` from the fields of `pfs_o` and leaves `pfs_o` unchanged.
- R5: When no call is present, `pfs_we_i` loads `pfs_i` into the previous-state register, and the value reads back on `pfs_o`. Otherwise `pfs_o` holds its value.
- R6: When a call and `pfs_we_i` occur in the same cycle, the call capture is stored and `pfs_i` is ignored.
- R7: Outside a call or return, `alloc_i` writes the size fields from `alloc_sizes_i`: frame size in bits 6:0, locals size in bits 13:7 and rotating size in bits 17:14. It leaves the rotating bases unchanged. The size fields change at no other time except on a return.
- R8: With no call, return or allocate pending, `rot_i` decrements each rotating base by one and wraps within its width. The general base (bits 24:18) and the floating-point base (bits 31:25) wrap from 0 to 127. The predicate base (bits 37:32) wraps from 0 to 63.
- R9: A second call overwrites the single saved level with the state live at that call.
- R10: When a call and a return occur in the same cycle, the call is performed and the return is ignored.
- R11: `pl_we_i` and `ec_we_i` update the privilege level and epilog count, except in a cycle with a taken return, where the restored values win.
- R12: Frame marker updates follow the priority call, return, allocate, rotate. The rotating bases change only on call, return or rotate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call event |
| ret_i | input | 1 | Return event |
| alloc_i | input | 1 | Allocate command |
| alloc_sizes_i | input | 18 | New size fields {sor, sol, sof} |
| rot_i | input | 1 | Loop-branch rotation event |
| pl_we_i | input | 1 | Privilege level write strobe |
| pl_i | input | 2 | Privilege level write data |
| ec_we_i | input | 1 | Epilog count write strobe |
| ec_i | input | 6 | Epilog count write data |
| pfs_we_i | input | 1 | Previous-state register write strobe |
| pfs_i | input | 46 | Previous-state register write data |
| pl_o | output | 2 | Live privilege level |
| ec_o | output | 6 | Live epilog count |
| cfm_o | output | 38 | Live frame marker |
| pfs_o | output | 46 | Previous-state register |

## Verification
The bench drives the collisions that a sloppy priority encoder gets wrong. A call with a software write of the previous-state register must keep the capture, not the written word. A call with a return must leave the live privilege level untouched, while a design that favoured the return would load stale saved fields. A return with privilege and epilog writes must keep the restored values. An allocate with a rotation must leave the bases unchanged. The bench also rotates from zero to check the wrap to 127 and 63, since a wrong field width would produce a different all-ones value. It then issues a second call to confirm that the saved level is overwritten rather than kept.

// File: rtl/frame_state_unit.sv
module frame_state_unit #(
  parameter int PL_W  = 2,
  parameter int EC_W  = 6,
  parameter int SZ_W  = 7,
  parameter int SOR_W = 4,
  parameter int GR_W  = 7,
  parameter int FR_W  = 7,
  parameter int PR_W  = 6,
  localparam int SIZES_W = 2*SZ_W + SOR_W,
  localparam int RRB_W   = GR_W + FR_W + PR_W,
  localparam int CFM_W   = SIZES_W + RRB_W,
  localparam int PFS_W   = PL_W + EC_W + CFM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic               alloc_i,
  input  logic [SIZES_W-1:0] alloc_sizes_i,
  input  logic               rot_i,
  input  logic               pl_we_i,
  input  logic [PL_W-1:0]    pl_i,
  input  logic               ec_we_i,
  input  logic [EC_W-1:0]    ec_i,
  input  logic               pfs_we_i,
  input  logic [PFS_W-1:0]   pfs_i,
  output logic [PL_W-1:0]    pl_o,
  output logic [EC_W-1:0]    ec_o,
  output logic [CFM_W-1:0]   cfm_o,
  output logic [PFS_W-1:0]   pfs_o
);
  logic [PL_W-1:0]  pl_q;
  logic [EC_W-1:0]  ec_q;
  logic [CFM_W-1:0] cfm_q;
  logic [PFS_W-1:0] pfs_q;

  logic             ret_take;
  logic [GR_W-1:0]  gr_q;
  logic [FR_W-1:0]  fr_q;
  logic [PR_W-1:0]  pr_q;

  assign ret_take = ret_i & ~call_i;
  assign gr_q = cfm_q[SIZES_W +: GR_W];
  assign fr_q = cfm_q[SIZES_W+GR_W +: FR_W];
  assign pr_q = cfm_q[SIZES_W+GR_W+FR_W +: PR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pl_q  <= '0;
      ec_q  <= '0;
      cfm_q <= '0;
      pfs_q <= '0;
    end else begin
      if (call_i)        pfs_q <= {pl_q, ec_q, cfm_q};
      else if (pfs_we_i) pfs_q <= pfs_i;

      if (call_i)        cfm_q <= {{RRB_W{1'b0}}, cfm_q[SIZES_W-1:0]};
      else if (ret_i)    cfm_q <= pfs_q[CFM_W-1:0];
      else if (alloc_i)  cfm_q[SIZES_W-1:0] <= alloc_sizes_i;
      else if (rot_i)    cfm_q[CFM_W-1:SIZES_W] <= {pr_q - 1'b1, fr_q - 1'b1, gr_q - 1'b1};

      if (ret_take)      pl_q <= pfs_q[PFS_W-1 -: PL_W];
      else if (pl_we_i)  pl_q <= pl_i;

      if (ret_take)      ec_q <= pfs_q[CFM_W +: EC_W];
      else if (ec_we_i)  ec_q <= ec_i;
    end
  end

  assign pl_o  = pl_q;
  assign ec_o  = ec_q;
  assign cfm_o = cfm_q;
  assign pfs_o = pfs_q;
endmodule

module frame_state_unit_chk #(
  parameter int PL_W = 2, parameter int EC_W = 6, parameter int SZ_W = 7,
  parameter int SOR_W = 4, parameter int GR_W = 7, parameter int FR_W = 7,
  parameter int PR_W = 6,
  localparam int SIZES_W = 2*SZ_W + SOR_W,
  localparam int CFM_W = SIZES_W + GR_W + FR_W + PR_W,
  localparam int PFS_W = PL_W + EC_W + CFM_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               call_i,
  input logic               ret_i,
  input logic               alloc_i,
  input logic               rot_i,
  input logic               pfs_we_i,
  input logic [PL_W-1:0]    pl_o,
  input logic [EC_W-1:0]    ec_o,
  input logic [CFM_W-1:0]   cfm_o,
  input logic [PFS_W-1:0]   pfs_o
);
  logic [GR_W-1:0] gr_p1;
  logic [FR_W-1:0] fr_p1;
  logic [PR_W-1:0] pr_p1;
  assign gr_p1 = cfm_o[SIZES_W +: GR_W] + 1'b1;
  assign fr_p1 = cfm_o[SIZES_W+GR_W +: FR_W] + 1'b1;
  assign pr_p1 = cfm_o[SIZES_W+GR_W+FR_W +: PR_W] + 1'b1;

  p_call_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> pfs_o == $past({pl_o, ec_o, cfm_o}));
  p_call_rrb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |=> (cfm_o[CFM_W-1:SIZES_W] == '0) && $stable(cfm_o[SIZES_W-1:0]));
  p_ret_restore_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !call_i) |=> ({pl_o, ec_o, cfm_o} == $past(pfs_o)) && $stable(pfs_o));
  p_pfs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!call_i && !pfs_we_i) |=> $stable(pfs_o));
  p_sizes_only_alloc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_i && !ret_i) |=> $stable(cfm_o[SIZES_W-1:0]));
  p_rotate_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_i && !call_i && !ret_i && !alloc_i) |=>
      (gr_p1 == $past(cfm_o[SIZES_W +: GR_W])) &&
      (fr_p1 == $past(cfm_o[SIZES_W+GR_W +: FR_W])) &&
      (pr_p1 == $past(cfm_o[SIZES_W+GR_W+FR_W +: PR_W])));
  p_rrb_only_events_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rot_i && !call_i && !ret_i) |=> $stable(cfm_o[CFM_W-1:SIZES_W]));
  p_alloc_blocks_rot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !call_i && !ret_i) |=> $stable(cfm_o[CFM_W-1:SIZES_W]));
endmodule

bind frame_state_unit frame_state_unit_chk #(
  .PL_W(PL_W), .EC_W(EC_W), .SZ_W(SZ_W), .SOR_W(SOR_W),
  .GR_W(GR_W), .FR_W(FR_W), .PR_W(PR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
  .alloc_i(alloc_i), .rot_i(rot_i), .pfs_we_i(pfs_we_i),
  .pl_o(pl_o), .ec_o(ec_o), .cfm_o(cfm_o), .pfs_o(pfs_o)
);

// File: tb/frame_state_unit_tb_top.sv
`timescale 1ns/1ps
module frame_state_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 0, ret_i = 0, alloc_i = 0, rot_i = 0;
  logic [17:0] alloc_sizes_i = '0;
  logic        pl_we_i = 0, ec_we_i = 0, pfs_we_i = 0;
  logic [1:0]  pl_i = '0;
  logic [5:0]  ec_i = '0;
  logic [45:0] pfs_i = '0;
  logic [1:0]  pl_o;
  logic [5:0]  ec_o;
  logic [37:0] cfm_o;
  logic [45:0] pfs_o;

  int total = 0, bad = 0;
  logic [1:0]  e_pl;
  logic [5:0]  e_ec;
  logic [37:0] e_cfm;
  logic [45:0] e_pfs;

  always #10 clk = ~clk;

  frame_state_unit dut_i (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .alloc_i(alloc_i), .alloc_sizes_i(alloc_sizes_i), .rot_i(rot_i),
    .pl_we_i(pl_we_i), .pl_i(pl_i), .ec_we_i(ec_we_i), .ec_i(ec_i),
    .pfs_we_i(pfs_we_i), .pfs_i(pfs_i),
    .pl_o(pl_o), .ec_o(ec_o), .cfm_o(cfm_o), .pfs_o(pfs_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " pl"}, 64'(pl_o), 64'(e_pl));
    chk({req, " ec"}, 64'(ec_o), 64'(e_ec));
    chk({req, " cfm"}, 64'(cfm_o), 64'(e_cfm));
    chk({req, " pfs"}, 64'(pfs_o), 64'(e_pfs));
  endtask

  task automatic tick();
    @(posedge clk); #5;
    call_i = 0; ret_i = 0; alloc_i = 0; rot_i = 0;
    pl_we_i = 0; ec_we_i = 0; pfs_we_i = 0;
  endtask

  function automatic logic [37:0] rotdec(logic [37:0] c);
    return {c[37:32] - 6'd1, c[31:25] - 7'd1, c[24:18] - 7'd1, c[17:0]};
  endfunction

  task automatic t_reset_r1();
    e_pl = '0; e_ec = '0; e_cfm = '0; e_pfs = '0;
    chk_all("R1");
  endtask

  task automatic t_setup_r7_r8();
    pl_we_i = 1; pl_i = 2'd2; ec_we_i = 1; ec_i = 6'd5;
    alloc_i = 1; alloc_sizes_i = 18'h2_1C35;
    tick();
    e_pl = 2'd2; e_ec = 6'd5; e_cfm = {20'h0, 18'h2_1C35};
    chk_all("R7 R11");
    rot_i = 1; tick();
    e_cfm = rotdec(e_cfm);
    chk("R8 wrap", 64'(cfm_o[37:18]), 64'({6'd63, 7'd127, 7'd127}));
    chk_all("R8");
    rot_i = 1; tick();
    e_cfm = rotdec(e_cfm);
    chk_all("R8 second");
  endtask

  task automatic t_call_r2_r3();
    e_pfs = {e_pl, e_ec, e_cfm};
    call_i = 1; tick();
    e_cfm = {20'h0, e_cfm[17:0]};
    chk_all("R2 R3");
  endtask

  task automatic t_pfs_write_ret_r5_r4();
    pl_we_i = 1; pl_i = 2'd1; ec_we_i = 1; ec_i = 6'd9;
    alloc_i = 1; alloc_sizes_i = 18'h0_4081;
    tick();
    e_pl = 2'd1; e_ec = 6'd9; e_cfm = {20'h0, 18'h0_4081};
    chk_all("R7 R12");
    pfs_we_i = 1; pfs_i = 46'h2A34_5678_9ABC; tick();
    e_pfs = 46'h2A34_5678_9ABC;
    chk_all("R5");
    ret_i = 1; tick();
    {e_pl, e_ec, e_cfm} = e_pfs;
    chk_all("R4");
  endtask

  task automatic t_call_vs_write_r6();
    pfs_we_i = 1; pfs_i = 46'h1555_0000_FFFF; call_i = 1;
    e_pfs = {e_pl, e_ec, e_cfm};
    tick();
    e_cfm = {20'h0, e_cfm[17:0]};
    chk_all("R6");
  endtask

  task automatic t_double_call_r9();
    pl_we_i = 1; pl_i = 2'd3; ec_we_i = 1; ec_i = 6'd33; tick();
    rot_i = 1; tick();
    e_pl = 2'd3; e_ec = 6'd33; e_cfm = rotdec(e_cfm);
    e_pfs = {e_pl, e_ec, e_cfm};
    call_i = 1; tick();
    e_cfm = {20'h0, e_cfm[17:0]};
    chk_all("R9");
  endtask

  task automatic t_call_vs_ret_r10();
    pfs_we_i = 1; pfs_i = 46'h0C00_ABCD_1234; tick();
    e_pfs = 46'h0C00_ABCD_1234;
    rot_i = 1; tick();
    e_cfm = rotdec(e_cfm);
    chk_all("R10 pre");
    call_i = 1; ret_i = 1;
    e_pfs = {e_pl, e_ec, e_cfm};
    tick();
    e_cfm = {20'h0, e_cfm[17:0]};
    chk_all("R10");
  endtask

  task automatic t_ret_vs_set_r11();
    pfs_we_i = 1; pfs_i = {2'd1, 6'd17, 38'h15_0000_0123}; tick();
    e_pfs = {2'd1, 6'd17, 38'h15_0000_0123};
    ret_i = 1; pl_we_i = 1; pl_i = 2'd2; ec_we_i = 1; ec_i = 6'd44; tick();
    {e_pl, e_ec, e_cfm} = e_pfs;
    chk_all("R11");
    pl_we_i = 1; pl_i = 2'd2; ec_we_i = 1; ec_i = 6'd44; tick();
    e_pl = 2'd2; e_ec = 6'd44;
    chk_all("R11 plain");
  endtask

  task automatic t_priority_r12();
    alloc_i = 1; rot_i = 1; alloc_sizes_i = 18'h3_FFFF; tick();
    e_cfm = {e_cfm[37:18], 18'h3_FFFF};
    chk_all("R12 alloc over rot");
    pfs_we_i = 1; pfs_i = {2'd0, 6'd1, 38'h3F_FFC0_0001}; tick();
    e_pfs = {2'd0, 6'd1, 38'h3F_FFC0_0001};
    ret_i = 1; alloc_i = 1; alloc_sizes_i = 18'h0_0007; rot_i = 1; tick();
    {e_pl, e_ec, e_cfm} = e_pfs;
    chk_all("R12 ret over alloc");
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    @(posedge clk); #5;
    t_reset_r1();
    t_setup_r7_r8();
    t_call_r2_r3();
    t_pfs_write_ret_r5_r4();
    t_call_vs_write_r6();
    t_double_call_r9();
    t_call_vs_ret_r10();
    t_ret_vs_set_r11();
    t_priority_r12();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule